// File: doc/BRIEF.md
# RTC Divider and Update-Cycle Controller

This block is the timebase of a CMOS-style real-time clock. A strobe that pulses once per period of the slow oscillator (nominally 32.768 kHz) advances a sub-second counter. Each time that counter wraps, the block issues a once-per-second update event. The calendar logic outside the block uses that event. The block owns two control registers and one status register, all behind a byte-wide port. The divider-select field can hold the counter in reset. An update-in-progress bit warns software shortly before each second boundary. The update-ended and alarm flags are latched at the boundary and drive an interrupt request.

Releasing the divider from its held state into a running setting of 010 or lower preloads the counter to half a second, so the first update comes half a second after the releasing write. Flags are raised only while the divider is in its normal setting (010) and the freeze bit of control register B is clear. The update-in-progress bit is forced low while the clock is frozen or held.

Top module: `rtc_update_ctrl`

## Requirements
- R1: While the divider field (control A, address 0, bits 6:4) is not of the form 11x, the sub-second counter advances once per `osc_tick`. It produces one second boundary every `TICKS_PER_SEC` ticks and restarts from zero after each boundary.
- R2: When control A bits 6 and 5 are both 1, the counter stays at zero and no boundary or flag occurs. After reset, control A reads 0x60, control B (address 1) reads 0x00 and status C (address 2) reads 0x00.
- R3: A write to control A that moves the divider field from held to a value of 010 or lower makes the next boundary come `TICKS_PER_SEC/2` ticks later. A release to a value above 010 restarts the counter from zero.
- R4: Control A bit 7 (update in progress) reads 1 exactly while the counter is in its last `UIP_TICKS` counts before a boundary, provided the divider is running and the freeze bit is clear.
- R5: Control A bit 7 is read-only: a write leaves it unchanged, and bits 6:0 read back as written.
- R6: Control A bit 7 reads 0 whenever control B bit 7 (freeze) is 1 or the divider is held. A write that puts the divider into hold clears it from the next cycle on.
- R7: Status C bit 4 (update ended) is set at a boundary only when the freeze bit is 0 and the divider field is 010.
- R8: Status C bit 5 (alarm) is set at a boundary when `alarm_match` is high, under the same conditions as R7.
- R9: A read of status C returns its flags and then clears them. A flag set by a boundary in the same cycle as the read survives.
- R10: `irq` and status C bit 7 are high while (bit 4 and control B bit 4) or (bit 5 and control B bit 5) holds. Control B reads back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_tick | input | 1 | One-cycle strobe per slow-oscillator period |
| alarm_match | input | 1 | High when the alarm registers equal the current time |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (clears status C when addressed) |
| addr | input | 2 | Register address: 0 control A, 1 control B, 2 status C |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from `addr` |
| irq | output | 1 | Interrupt request |

## Verification
On every cycle, the assertions check the following:
- no boundary happens while the divider is held;
- the counter lands on the half-second preload after a release;
- the counter wraps to zero after a boundary;
- update-in-progress is high in the cycle a boundary fires;
- flags rise only on a gated boundary, and a plain read clears them.

Only the bench scenarios can show the exact placement of the update-in-progress window relative to a write. They also show the difference between releasing to 001/010 and releasing to 100, the masking by the freeze bit, the read/set collision on status C and the end-to-end interrupt path.

// File: rtl/rtcdiv_pkg.sv
package rtcdiv_pkg;
  localparam logic [1:0] ADDR_CTRL_A = 2'd0;
  localparam logic [1:0] ADDR_CTRL_B = 2'd1;
  localparam logic [1:0] ADDR_STAT_C = 2'd2;
  localparam logic [2:0] DIV_NORMAL  = 3'b010;

  // Divider field holds the chain in reset when its two upper bits are set.
  function automatic logic div_is_held(input logic [2:0] f);
    return f[2] & f[1];
  endfunction

  // Settings that take the half-second restart when leaving hold.
  function automatic logic div_may_restart(input logic [2:0] f);
    return f <= DIV_NORMAL;
  endfunction

  // True in the last 'win' counts of a 'total'-count second.
  function automatic logic in_uip_window(input int unsigned cnt,
                                         input int unsigned total,
                                         input int unsigned win);
    return (cnt + win) >= total;
  endfunction
endpackage

// File: rtl/rtcdiv_counter.sv
module rtcdiv_counter
  import rtcdiv_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768,
  parameter int UIP_TICKS     = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic osc_tick,
  input  logic restart,
  input  logic clear,
  input  logic held,
  input  logic set_bit,
  output logic sec_pulse,
  output logic uip
);
  localparam int CNT_W = $clog2(TICKS_PER_SEC);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TICKS_PER_SEC - 1);
  localparam logic [CNT_W-1:0] HALF = CNT_W'(TICKS_PER_SEC / 2);

  logic [CNT_W-1:0] cnt_q;
  logic             at_last;

  assign at_last   = (cnt_q == LAST);
  assign sec_pulse = osc_tick && at_last && !restart && !clear;

  always_ff @(posedge clk) begin
    if (!rst_n)        cnt_q <= '0;
    else if (restart)  cnt_q <= HALF;
    else if (clear)    cnt_q <= '0;
    else if (osc_tick) cnt_q <= at_last ? '0 : cnt_q + 1'b1;
  end

  assign uip = !held && !set_bit &&
               in_uip_window(32'(cnt_q), TICKS_PER_SEC, UIP_TICKS);

  assert_wrap_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    sec_pulse |=> (cnt_q == '0));
  assert_hold_silent_R2: assert property (@(posedge clk) disable iff (!rst_n)
    held |-> !sec_pulse);
  assert_restart_half_R3: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt_q == HALF));
  assert_uip_leads_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_pulse && !set_bit) |-> uip);
endmodule

// File: rtl/rtcdiv_flags.sv
module rtcdiv_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic sec_pulse,
  input  logic normal,
  input  logic alarm_hit,
  input  logic rd_clr,
  input  logic uie,
  input  logic aie,
  output logic uf,
  output logic af,
  output logic irq
);
  logic gated_sec;
  assign gated_sec = sec_pulse && normal;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      uf <= 1'b0;
      af <= 1'b0;
    end else begin
      uf <= (uf && !rd_clr) || gated_sec;
      af <= (af && !rd_clr) || (gated_sec && alarm_hit);
    end
  end

  assign irq = (uf && uie) || (af && aie);

  assert_uf_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(uf) |-> $past(sec_pulse && normal));
  assert_af_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(af) |-> $past(sec_pulse && normal && alarm_hit));
  assert_read_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && !gated_sec) |=> (!uf && !af));
  assert_irq_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (uf || af));
endmodule

// File: rtl/rtc_update_ctrl.sv
module rtc_update_ctrl
  import rtcdiv_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768,
  parameter int UIP_TICKS     = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       osc_tick,
  input  logic       alarm_match,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [1:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       irq
);
  logic [6:0] ctl_a_q;
  logic [7:0] ctl_b_q;
  logic [2:0] field;
  logic       held_q, set_bit, wr_a, restart, enter_hold, clear;
  logic       rd_clr, normal, sec_pulse, uip, uf, af;

  assign field      = ctl_a_q[6:4];
  assign held_q     = div_is_held(field);
  assign set_bit    = ctl_b_q[7];
  assign wr_a       = wr_en && (addr == ADDR_CTRL_A);
  assign restart    = wr_a && held_q && div_may_restart(wdata[6:4]);
  assign enter_hold = wr_a && !held_q && div_is_held(wdata[6:4]);
  assign clear      = held_q || enter_hold;
  assign rd_clr     = rd_en && (addr == ADDR_STAT_C);
  assign normal     = (field == DIV_NORMAL) && !set_bit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_a_q <= 7'h60;
      ctl_b_q <= 8'h00;
    end else if (wr_en) begin
      if (addr == ADDR_CTRL_A) ctl_a_q <= wdata[6:0];
      if (addr == ADDR_CTRL_B) ctl_b_q <= wdata;
    end
  end

  rtcdiv_counter #(
    .TICKS_PER_SEC(TICKS_PER_SEC),
    .UIP_TICKS    (UIP_TICKS)
  ) u_counter (
    .clk      (clk),
    .rst_n    (rst_n),
    .osc_tick (osc_tick),
    .restart  (restart),
    .clear    (clear),
    .held     (held_q),
    .set_bit  (set_bit),
    .sec_pulse(sec_pulse),
    .uip      (uip)
  );

  rtcdiv_flags u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .sec_pulse(sec_pulse),
    .normal   (normal),
    .alarm_hit(alarm_match),
    .rd_clr   (rd_clr),
    .uie      (ctl_b_q[4]),
    .aie      (ctl_b_q[5]),
    .uf       (uf),
    .af       (af),
    .irq      (irq)
  );

  always_comb begin
    case (addr)
      ADDR_CTRL_A: rdata = {uip, ctl_a_q};
      ADDR_CTRL_B: rdata = ctl_b_q;
      ADDR_STAT_C: rdata = {irq, 1'b0, af, uf, 4'b0000};
      default:     rdata = 8'h00;
    endcase
  end

  assert_keep_bits_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_a |=> (rdata[6:0] == $past(wdata[6:0]) || addr != ADDR_CTRL_A));
  assert_hold_clears_uip_R6: assert property (@(posedge clk) disable iff (!rst_n)
    enter_hold |=> !uip);
endmodule

// File: tb/rtc_update_ctrl_tb.sv
module rtc_update_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       osc_tick = 1'b0;
  logic       alarm_match = 1'b0;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       irq;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } item_t;
  item_t sb_q[$];

  always #2 clk = ~clk;  // 250 MHz

  rtc_update_ctrl #(.TICKS_PER_SEC(64), .UIP_TICKS(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .alarm_match(alarm_match),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .irq(irq)
  );

  // Monitor: one ns before the rising edge, compares each read against the queue.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (rd_en && sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        n_checks++;
        if (rdata !== it.exp) begin
          n_fail++;
          $display("FAIL %s: rdata=%02h expected=%02h", it.tag, rdata, it.exp);
        end
      end
    end
  end

  task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string tag);
    addr = a; rd_en = 1'b1;
    sb_q.push_back('{exp: exp, tag: tag});
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_irq(input logic exp, input string tag);
    n_checks++;
    if (irq !== exp) begin
      n_fail++;
      $display("FAIL %s: irq=%0b expected=%0b", tag, irq, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    osc_tick = 1'b1;
    // Reset state and hold (R2)
    rd(2'd0, 8'h60, "R2 reset ctrl A");
    rd(2'd1, 8'h00, "R10 reset ctrl B");
    rd(2'd2, 8'h00, "R2 reset stat C");
    chk_irq(1'b0, "R2 reset irq");
    run(100);
    rd(2'd2, 8'h00, "R2 no flags while held");
    rd(2'd0, 8'h60, "R2 no UIP while held");
    // Release to normal: counter preloaded to 32 of 64 (R3)
    wr(2'd0, 8'h2F);                        // cnt 32
    rd(2'd0, 8'h2F, "R5 readback");         // -> 33
    run(22);                                // 55
    rd(2'd0, 8'h2F, "R4 UIP low before window"); // -> 56
    rd(2'd0, 8'hAF, "R3 R4 UIP at half-second window"); // -> 57
    wr(2'd0, 8'h2F);                        // -> 58, no restart
    rd(2'd0, 8'hAF, "R5 write keeps UIP");  // -> 59
    run(3);                                 // 62
    rd(2'd2, 8'h00, "R1 no flag before boundary"); // -> 63
    rd(2'd2, 8'h00, "R9 read at boundary cycle");  // boundary, cnt 0
    rd(2'd2, 8'h10, "R7 R9 UF survives colliding read"); // -> 1
    rd(2'd2, 8'h00, "R9 read clears");      // -> 2
    rd(2'd0, 8'h2F, "R4 UIP low after boundary"); // -> 3
    // Interrupt path (R8, R10)
    wr(2'd1, 8'h10);                        // -> 4
    rd(2'd1, 8'h10, "R10 ctrl B readback"); // -> 5
    alarm_match = 1'b1;
    run(58);                                // 63
    chk_irq(1'b0, "R1 R10 no irq one tick early");
    run(1);                                 // boundary
    chk_irq(1'b1, "R10 irq from UF");
    rd(2'd2, 8'hB0, "R8 R10 flags with IRQF"); // -> 1
    chk_irq(1'b0, "R9 irq drops after read");
    alarm_match = 1'b0;
    // Freeze bit masks UIP and flags (R6, R7)
    wr(2'd1, 8'h90);                        // -> 2
    run(53);                                // 55
    rd(2'd0, 8'h2F, "R6 pre-window");       // -> 56
    rd(2'd0, 8'h2F, "R6 UIP masked by freeze"); // -> 57
    run(7);                                 // boundary, cnt 0
    rd(2'd2, 8'h00, "R7 no UF while frozen"); // -> 1
    wr(2'd1, 8'h10);                        // -> 2
    // Non-normal running mode (R7), UIP write ignored (R5)
    wr(2'd0, 8'h8F);                        // field 000, -> 3
    rd(2'd0, 8'h0F, "R5 bit 7 write ignored"); // -> 4
    run(60);                                // boundary, cnt 0
    rd(2'd2, 8'h00, "R7 no UF in mode 000"); // -> 1
    // Entering hold clears UIP (R6)
    wr(2'd0, 8'h2F);                        // -> 2
    run(54);                                // 56
    rd(2'd0, 8'hAF, "R4 UIP in window");    // -> 57
    wr(2'd0, 8'h6F);                        // held, cnt 0
    rd(2'd0, 8'h6F, "R6 hold clears UIP");
    run(100);
    rd(2'd2, 8'h00, "R2 no boundary in hold");
    // Release above 010 restarts from zero (R3)
    wr(2'd0, 8'h4F);                        // cnt 0
    run(30);                                // 30
    rd(2'd0, 8'h4F, "R3 no preload for 100"); // -> 31
    wr(2'd0, 8'h6F);                        // held
    wr(2'd0, 8'h1F);                        // preload 32
    run(23);                                // 55
    rd(2'd0, 8'h1F, "R3 mode 001 pre-window"); // -> 56
    rd(2'd0, 8'h9F, "R3 R4 mode 001 half-second"); // -> 57
    run(2);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule